// File: doc/BRIEF.md
# Trap Request Arbiter

The arbiter keeps one pending bit for each of fifteen processor trap and abort sources of a 16-bit minicomputer core. Each cycle it names the most urgent pending source and gives its fixed vector address. A single-cycle set pulse on a source's input makes that source pending. When the core takes the trap, it raises the service strobe. At that clock edge the arbiter clears the selected source together with a source-specific group of lower-priority requests that the trap makes moot.

In the same strobe cycle the arbiter reports two things for the memory-management unit: whether status register 1 should be cleared, and whether the vector should be logged into status register 2. Both reports are held off while the core marks those registers as frozen. A kernel stack abort pulse discards every pending request and leaves only the red-stack abort pending.

The stack push, the fetch of the new PC and PSW, and device interrupt vectoring belong to the surrounding core.

Top module: `trap_arb`

## Requirements
- R1: After reset, pend_o is 0, none_o is 1, and vec_o and sel_o are 0.
- R2: A 1 on set_i[k] at a clock edge makes pend_o[k] 1 from that edge on. It stays 1 until the source is cleared. The bit positions in priority order are: 0 red stack, 1 odd address, 2 nonexistent memory, 3 memory management, 4 parity, 5 privileged, 6 illegal, 7 breakpoint, 8 IOT, 9 EMT, 10 TRAP, 11 trace, 12 yellow stack, 13 power fail, 14 floating-point exception.
- R3: sel_o is the lowest pending bit index (the highest priority), and none_o is 0 while any bit is pending.
- R4: vec_o shows the selected source's vector, in octal: 4 for red, odd, nonexistent memory, privileged and yellow; 250 for memory management; 114 for parity; 10 for illegal; 14 for breakpoint and trace; 20 for IOT; 30 for EMT; 34 for TRAP; 24 for power fail; 244 for FP exception.
- R5: Nonexistent memory (bit 2) is selected over memory management (bit 3).
- R6: Servicing an abort clears a group of bits. Red clears bits {0,1,2,3,4,11,12}. Odd clears {1,2,3,4,11,12}. Nonexistent memory clears {2,3,4,11,12}. Memory management clears {3,4,11,12}. Parity clears {4,11,12}.
- R7: Servicing bits 5 to 10 clears that bit and trace (bit 11). Servicing bits 11 to 14 clears only that bit.
- R8: A set pulse arriving in the same cycle as a clear of that bit wins, so the bit stays pending.
- R9: A kstk_abort_i pulse makes pend_o exactly bit 0 after the edge. This overrides any concurrent set or service.
- R10: clr_sr1_o is 1 in a cycle with svc_i high, frozen_i low and a request pending; otherwise it is 0.
- R11: ld_sr2_o is 1 under the same conditions as R10, except when the selected source is one of bits 5 to 10.
- R12: While frozen_i is high, clr_sr1_o and ld_sr2_o stay 0, but service still clears pending bits.
- R13: svc_i with nothing pending changes no state and raises neither report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 15 | Per-source request pulses |
| svc_i | input | 1 | Trap taken: clear selected group |
| kstk_abort_i | input | 1 | Kernel stack abort pulse |
| frozen_i | input | 1 | Memory-management status registers frozen |
| pend_o | output | 15 | Pending request bits |
| none_o | output | 1 | No request pending |
| sel_o | output | 4 | Index of selected source |
| vec_o | output | 16 | Vector address of selected source |
| clr_sr1_o | output | 1 | Clear status register 1 this cycle |
| ld_sr2_o | output | 1 | Load vector into status register 2 this cycle |

## Verification
Pending bits register on the edge that samples a set, service or stack-abort input, so pend_o, sel_o, vec_o and none_o are due one edge after the stimulus. The bench reads them at the following falling edge. clr_sr1_o and ld_sr2_o are combinational from the current selection and the strobe. The bench therefore checks them one nanosecond after driving the strobe at a falling edge, before the edge that performs the clear. Each table row starts from reset, so a result never carries over from an earlier row.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;
  localparam int NSRC  = 15;
  localparam int IDX_W = $clog2(NSRC);
  localparam int VEC_W = 16;

  typedef enum logic [IDX_W-1:0] {
    SRC_RED = 4'd0, SRC_ODD = 4'd1, SRC_NXM = 4'd2, SRC_MME = 4'd3,
    SRC_PAR = 4'd4, SRC_PRV = 4'd5, SRC_ILL = 4'd6, SRC_BPT = 4'd7,
    SRC_IOT = 4'd8, SRC_EMT = 4'd9, SRC_TRP = 4'd10, SRC_TRC = 4'd11,
    SRC_YEL = 4'd12, SRC_PWR = 4'd13, SRC_FPE = 4'd14
  } src_e;

  localparam logic [NSRC-1:0] TRC_BIT = NSRC'(1) << SRC_TRC;
  localparam logic [NSRC-1:0] YEL_BIT = NSRC'(1) << SRC_YEL;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] s);
    case (s)
      SRC_MME: vec_of = VEC_W'('o250);
      SRC_PAR: vec_of = VEC_W'('o114);
      SRC_ILL: vec_of = VEC_W'('o10);
      SRC_BPT, SRC_TRC: vec_of = VEC_W'('o14);
      SRC_IOT: vec_of = VEC_W'('o20);
      SRC_EMT: vec_of = VEC_W'('o30);
      SRC_TRP: vec_of = VEC_W'('o34);
      SRC_PWR: vec_of = VEC_W'('o24);
      SRC_FPE: vec_of = VEC_W'('o244);
      default: vec_of = VEC_W'('o4);
    endcase
  endfunction

  // companion requests dropped when source s is taken
  function automatic logic [NSRC-1:0] clr_of(input logic [IDX_W-1:0] s);
    logic [NSRC-1:0] self;
    self = NSRC'(1) << s;
    if (s <= SRC_PAR) begin
      // aborts: self and every abort below it up to parity, plus trace, yellow
      clr_of = (~((NSRC'(1) << s) - NSRC'(1)) & NSRC'(5'h1F)) | TRC_BIT | YEL_BIT;
    end else if (s <= SRC_TRP) begin
      clr_of = self | TRC_BIT;
    end else begin
      clr_of = self;
    end
  endfunction

  // instruction traps do not log their vector
  function automatic logic logs_of(input logic [IDX_W-1:0] s);
    logs_of = !(s >= SRC_PRV && s <= SRC_TRP);
  endfunction
endpackage

// File: rtl/trap_pend_reg.sv
module trap_pend_reg #(
  parameter int N = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         kstk_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q, pend_d;

  always_comb begin
    if (kstk_i) pend_d = N'(1);
    else        pend_d = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  a_r9_kstk_only_red: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kstk_i |=> (pend_q == N'(1)));
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!kstk_i && set_i == '0 && clr_i == '0) |=> $stable(pend_q));
  a_r8_set_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!kstk_i && set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/trap_prio_pick.sv
module trap_prio_pick #(
  parameter int N = 15,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pend_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          none_o
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_o[i]   = pend_i[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | pend_i[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (grant_o[i]) idx_o = idx_o | IW'(i);
  end

  assign none_o = ~blocked[N];

  a_r3_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && ((grant_o & ~pend_i) == '0));
  a_r3_none_iff_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    none_o == (grant_o == '0));
endmodule

// File: rtl/trap_svc_lut.sv
module trap_svc_lut
  import trap_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             none_i,
  input  logic             svc_i,
  input  logic             frozen_i,
  output logic [VEC_W-1:0] vec_o,
  output logic [NSRC-1:0]  clr_o,
  output logic             clr_sr1_o,
  output logic             ld_sr2_o
);
  logic take;
  assign take      = svc_i & ~none_i;
  assign vec_o     = none_i ? '0 : vec_of(idx_i);
  assign clr_o     = take ? clr_of(idx_i) : '0;
  assign clr_sr1_o = take & ~frozen_i;
  assign ld_sr2_o  = clr_sr1_o & logs_of(idx_i);

  a_r12_frozen_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_i |-> (!clr_sr1_o && !ld_sr2_o));
  a_r11_ld_needs_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_sr2_o |-> clr_sr1_o);
  a_r13_idle_svc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    none_i |-> (clr_o == '0 && vec_o == '0 && !clr_sr1_o));
endmodule

// File: rtl/trap_arb.sv
module trap_arb
  import trap_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  set_i,
  input  logic             svc_i,
  input  logic             kstk_abort_i,
  input  logic             frozen_i,
  output logic [NSRC-1:0]  pend_o,
  output logic             none_o,
  output logic [IDX_W-1:0] sel_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             clr_sr1_o,
  output logic             ld_sr2_o
);
  logic [NSRC-1:0]  pend, grant, clr;
  logic [IDX_W-1:0] idx;
  logic             none;

  trap_pend_reg #(.N(NSRC)) i_pend (
    .clk_i, .rst_ni, .set_i, .clr_i(clr), .kstk_i(kstk_abort_i), .pend_o(pend)
  );

  trap_prio_pick #(.N(NSRC)) i_pick (
    .clk_i, .rst_ni, .pend_i(pend), .grant_o(grant), .idx_o(idx), .none_o(none)
  );

  trap_svc_lut i_lut (
    .clk_i, .rst_ni, .idx_i(idx), .none_i(none), .svc_i, .frozen_i,
    .vec_o, .clr_o(clr), .clr_sr1_o, .ld_sr2_o
  );

  assign pend_o = pend;
  assign none_o = none;
  assign sel_o  = idx;

  a_r6_taken_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_i && !none && !kstk_abort_i && !set_i[idx]) |=> !pend[$past(idx)]);
  a_r3_sel_is_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !none |-> (pend[idx] && grant[idx]));
  a_r1_none_zero_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    none |-> (vec_o == '0));
endmodule

// File: tb/test_trap_arb.sv
module test_trap_arb;
  localparam time PERIOD = 20ns;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [14:0] set_i = '0;
  logic        svc_i = 1'b0, kstk_abort_i = 1'b0, frozen_i = 1'b0;
  logic [14:0] pend_o;
  logic        none_o, clr_sr1_o, ld_sr2_o;
  logic [3:0]  sel_o;
  logic [15:0] vec_o;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk_i = ~clk_i;

  trap_arb i_trap_arb (.*);

  typedef struct packed {
    logic [14:0] set;
    logic [3:0]  sel;
    logic [15:0] vec;
    logic [14:0] after;
    logic        ld;
  } row_t;

  // set mask, selected index, vector, pending after one service, status-2 load
  localparam row_t TBL [15] = '{
    '{15'h7FFF, 4'd0,  16'o4,   15'h67E0, 1'b1},  // R6 red
    '{15'h2016, 4'd1,  16'o4,   15'h2000, 1'b1},  // R6 odd
    '{15'h000C, 4'd2,  16'o4,   15'h0000, 1'b1},  // R5 nxm over mme
    '{15'h2818, 4'd3,  16'o250, 15'h2000, 1'b1},  // R6 mme
    '{15'h5010, 4'd4,  16'o114, 15'h4000, 1'b1},  // R6 parity
    '{15'h1820, 4'd5,  16'o4,   15'h1000, 1'b0},  // R7 privileged
    '{15'h08C0, 4'd6,  16'o10,  15'h0080, 1'b0},  // R7 illegal
    '{15'h0880, 4'd7,  16'o14,  15'h0000, 1'b0},  // R7 breakpoint
    '{15'h0300, 4'd8,  16'o20,  15'h0200, 1'b0},  // R7 IOT
    '{15'h0A00, 4'd9,  16'o30,  15'h0000, 1'b0},  // R7 EMT
    '{15'h1C00, 4'd10, 16'o34,  15'h1000, 1'b0},  // R7 TRAP
    '{15'h1800, 4'd11, 16'o14,  15'h1000, 1'b1},  // R7 trace
    '{15'h3000, 4'd12, 16'o4,   15'h2000, 1'b1},  // R7 yellow
    '{15'h6000, 4'd13, 16'o24,  15'h4000, 1'b1},  // R7 power
    '{15'h4000, 4'd14, 16'o244, 15'h0000, 1'b1}   // R7 fp
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; set_i = '0; svc_i = 1'b0; kstk_abort_i = 1'b0; frozen_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // drive at a falling edge, let one rising edge register, return at next falling edge
  task automatic pulse_set(input logic [14:0] m);
    set_i = m;
    @(negedge clk_i);
    set_i = '0;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk(pend_o == '0, "R1 pend", pend_o, 0);
    chk(none_o == 1'b1, "R1 none", none_o, 1);
    chk(vec_o == '0 && sel_o == '0, "R1 vec/sel", {sel_o, vec_o}, 0);

    for (int k = 0; k < 15; k++) begin
      do_reset();
      pulse_set(TBL[k].set);
      chk(pend_o == TBL[k].set, "R2 pend after set", pend_o, TBL[k].set);
      chk(sel_o == TBL[k].sel && !none_o, "R3 sel", sel_o, TBL[k].sel);
      chk(vec_o == TBL[k].vec, "R4 vec", vec_o, TBL[k].vec);
      svc_i = 1'b1;
      #1;
      chk(clr_sr1_o == 1'b1, "R10 clr_sr1", clr_sr1_o, 1);
      chk(ld_sr2_o == TBL[k].ld, "R11 ld_sr2", ld_sr2_o, TBL[k].ld);
      @(negedge clk_i);
      svc_i = 1'b0;
      chk(pend_o == TBL[k].after, "R6/R7 clear group", pend_o, TBL[k].after);
    end

    // R2: pending held across idle cycles
    do_reset();
    pulse_set(15'h0041);
    repeat (3) @(negedge clk_i);
    chk(pend_o == 15'h0041, "R2 hold", pend_o, 15'h0041);

    // R12: frozen suppresses reports, still clears
    frozen_i = 1'b1; svc_i = 1'b1;
    #1;
    chk(!clr_sr1_o && !ld_sr2_o, "R12 reports", {clr_sr1_o, ld_sr2_o}, 0);
    @(negedge clk_i);
    svc_i = 1'b0; frozen_i = 1'b0;
    chk(pend_o == 15'h0040, "R12 clear while frozen", pend_o, 15'h0040);

    // R8: set of the serviced source in the same cycle keeps it pending
    do_reset();
    pulse_set(15'h0803);
    svc_i = 1'b1; set_i = 15'h0001;
    @(negedge clk_i);
    svc_i = 1'b0; set_i = '0;
    chk(pend_o == 15'h0001, "R8 set wins", pend_o, 15'h0001);

    // R9: kernel stack abort overrides set and service
    do_reset();
    pulse_set(15'h7F0E);
    kstk_abort_i = 1'b1; svc_i = 1'b1; set_i = 15'h4010;
    @(negedge clk_i);
    kstk_abort_i = 1'b0; svc_i = 1'b0; set_i = '0;
    chk(pend_o == 15'h0001, "R9 only red", pend_o, 15'h0001);
    chk(vec_o == 16'o4 && sel_o == 4'd0, "R9 red vector", vec_o, 16'o4);

    // R13: service with nothing pending
    do_reset();
    svc_i = 1'b1;
    #1;
    chk(!clr_sr1_o && !ld_sr2_o, "R13 no reports", {clr_sr1_o, ld_sr2_o}, 0);
    @(negedge clk_i);
    svc_i = 1'b0;
    chk(pend_o == '0 && none_o, "R13 no state change", pend_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule